// File: doc/BRIEF.md
# RS-485 Transceiver Direction Controller

This block sits next to a 16550-style UART and drives the control pins of an external RS-485/RS-422 line transceiver: the line-driver enable, the receiver enable and the bus termination enable. Software programs an 8-bit port control register over a simple register bus. That register selects one of four wire modes and holds a global transceiver enable and a termination bit.

The UART supplies its DTR output, a flag that its transmit FIFO holds data, and a flag that its transmit shift register is still shifting a character. From these inputs and the register, the block decides in every cycle whether the line driver is on and whether the receiver listens. It then registers the decision onto the pins, so the transceiver never sees a combinational glitch.

The wire mode controls three things: whether the driver is on all the time, follows DTR, or follows pending transmit data; and whether the receiver is blanked while the driver is on. Clearing the global enable silences both the driver and the receiver in every mode. The termination pin is independent of the other controls.

Top module: `xcvr_dir_ctrl`

## Requirements
- R1: Synchronous active-low reset loads the control register with 0x03 (automatic mode, transceiver disabled, termination off) and drives `drv_en`, `rcv_en` and `term_en` low.
- R2: The control register answers only at address 0x0F. A write there stores all 8 bits, and all 8 bits read back as written on `reg_rdata` whenever `reg_addr` is 0x0F. Writes to any other address leave the register unchanged, and reads at any other address return 0x00.
- R3: When bit 3 of the control register (transceiver enable) is 0, `drv_en` and `rcv_en` are both 0 whatever the wire mode and inputs.
- R4: With bit 3 set and bits [1:0] = 0 (four-wire full duplex), `drv_en` and `rcv_en` are both 1.
- R5: With bit 3 set and bits [1:0] = 1 (two-wire echo), `drv_en` equals `dtr` and `rcv_en` is 1.
- R6: With bit 3 set and bits [1:0] = 2 (two-wire DTR-keyed), `drv_en` equals `dtr` and `rcv_en` is its inverse.
- R7: With bit 3 set and bits [1:0] = 3 (two-wire automatic), `drv_en` is 1 while `tx_fifo_nonempty` or `tx_shift_busy` is 1, and `rcv_en` is its inverse. `drv_en` falls one cycle after both inputs are 0.
- R8: `term_en` equals bit 6 of the control register, whatever the enable bit and the wire mode.
- R9: All three pin outputs are registered. A change on an input or in the register shows at the pins one clock edge later, never in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register bus address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on address) |
| dtr | input | 1 | DTR output of the UART, 1 = asserted |
| tx_fifo_nonempty | input | 1 | Transmit FIFO holds at least one character |
| tx_shift_busy | input | 1 | Transmit shift register still sending, up to the last stop bit |
| drv_en | output | 1 | Line-driver enable to the transceiver |
| rcv_en | output | 1 | Receiver enable to the transceiver |
| term_en | output | 1 | Bus termination enable |

## Verification
A register write that changes the mode or the enable bit can land in the same cycle that the UART's DTR or transmit flags change. The pins for that edge must follow the old register contents combined with the new inputs, and the next edge must reflect the new register contents. The bench provokes this with random writes at address 0x0F interleaved with random toggling of `dtr`, `tx_fifo_nonempty` and `tx_shift_busy` on the same cycles. Each pin value is compared against a bench model that applies a write only after the edge that stores it.

// File: rtl/xcvr_dir_pkg.sv
// Shared constants and types for the transceiver direction controller.
// Assumes the 8-bit control register layout used by the whole block.
package xcvr_dir_pkg;

    localparam int unsigned CTRL_W      = 8;
    localparam int unsigned MODE_LSB    = 0;
    localparam int unsigned MODE_W      = 2;
    localparam int unsigned XCVR_EN_BIT = 3;
    localparam int unsigned TERM_BIT    = 6;

    localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h03;

    typedef enum logic [MODE_W-1:0] {
        WM_FULL_DUPLEX = 2'd0,
        WM_ECHO        = 2'd1,
        WM_DTR_HALF    = 2'd2,
        WM_AUTO_HALF   = 2'd3
    } wire_mode_e;

endpackage

// File: rtl/xcvr_ctrl_reg.sv
// Port control register. Stores all bits on a write at CTRL_ADDR and
// returns them on reads at that address, and zero elsewhere.
// Assumes one write per cycle and a read path that is sampled by the bus.
module xcvr_ctrl_reg #(
    parameter int unsigned            ADDR_W    = 4,
    parameter int unsigned            DATA_W    = 8,
    parameter logic [ADDR_W-1:0]      CTRL_ADDR = 4'hF,
    parameter logic [DATA_W-1:0]      RST_VAL   = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ctrl_q
);

    logic hit;

    // Address decode shared by the write and read paths.
    assign hit = (addr == CTRL_ADDR);

    // Register storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= RST_VAL;
        end else if (wr && hit) begin
            ctrl_q <= wdata;
        end
    end

    // Read mux: contents at the register address, zero elsewhere.
    always_comb begin
        rdata = hit ? ctrl_q : '0;
    end

    // R2: a write to another address must not disturb the register.
    p_foreign_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !hit) |=> $stable(ctrl_q));

endmodule

// File: rtl/xcvr_mode_decode.sv
// Combinational decision of driver and receiver enables from the wire
// mode, the global enable and the UART status inputs.
// Assumes the inputs are already synchronous to clk.
module xcvr_mode_decode
    import xcvr_dir_pkg::*;
(
    input  wire_mode_e mode,
    input  logic       xcvr_en,
    input  logic       dtr,
    input  logic       tx_pending,
    input  logic       tx_busy,
    output logic       nxt_drv,
    output logic       nxt_rcv
);

    logic drv_raw;
    logic rcv_raw;

    // Per-mode driver and receiver choice before the global gate.
    always_comb begin
        unique case (mode)
            WM_FULL_DUPLEX: begin
                drv_raw = 1'b1;
                rcv_raw = 1'b1;
            end
            WM_ECHO: begin
                drv_raw = dtr;
                rcv_raw = 1'b1;
            end
            WM_DTR_HALF: begin
                drv_raw = dtr;
                rcv_raw = !dtr;
            end
            default: begin
                drv_raw = tx_pending || tx_busy;
                rcv_raw = !(tx_pending || tx_busy);
            end
        endcase
    end

    // Global transceiver gate forces both directions off.
    always_comb begin
        nxt_drv = xcvr_en && drv_raw;
        nxt_rcv = xcvr_en && rcv_raw;
    end

endmodule

// File: rtl/xcvr_pin_reg.sv
// Output flops for the transceiver pins, so no combinational glitch
// reaches the board. Assumes a reset value of all zeros is safe.
module xcvr_pin_reg #(
    parameter int unsigned PIN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] d,
    output logic [PIN_W-1:0] q
);

    // One flop per pin with synchronous reset to off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/xcvr_dir_ctrl.sv
// Top of the transceiver direction controller. Connects the control
// register, the mode decoder and the pin flops. Assumes all inputs are
// synchronous to clk and the register bus is single-cycle.
module xcvr_dir_ctrl
    import xcvr_dir_pkg::*;
#(
    parameter int unsigned        ADDR_W    = 4,
    parameter logic [ADDR_W-1:0]  CTRL_ADDR = 4'hF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rdata,
    input  logic              dtr,
    input  logic              tx_fifo_nonempty,
    input  logic              tx_shift_busy,
    output logic              drv_en,
    output logic              rcv_en,
    output logic              term_en
);

    localparam int unsigned PIN_W = 3;

    logic [CTRL_W-1:0] ctrl_q;
    wire_mode_e        mode;
    logic              xcvr_en;
    logic              nxt_drv;
    logic              nxt_rcv;
    logic [PIN_W-1:0]  pin_d;
    logic [PIN_W-1:0]  pin_q;

    xcvr_ctrl_reg #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (CTRL_W),
        .CTRL_ADDR (CTRL_ADDR),
        .RST_VAL   (CTRL_RESET)
    ) ctrl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (reg_addr),
        .wr     (reg_wr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .ctrl_q (ctrl_q)
    );

    // Field extraction from the stored control word.
    assign mode    = wire_mode_e'(ctrl_q[MODE_LSB +: MODE_W]);
    assign xcvr_en = ctrl_q[XCVR_EN_BIT];

    xcvr_mode_decode dec_i (
        .mode       (mode),
        .xcvr_en    (xcvr_en),
        .dtr        (dtr),
        .tx_pending (tx_fifo_nonempty),
        .tx_busy    (tx_shift_busy),
        .nxt_drv    (nxt_drv),
        .nxt_rcv    (nxt_rcv)
    );

    // Pack the three pin decisions for the output flops.
    assign pin_d = {ctrl_q[TERM_BIT], nxt_rcv, nxt_drv};

    xcvr_pin_reg #(
        .PIN_W (PIN_W)
    ) pins_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_d),
        .q     (pin_q)
    );

    assign drv_en  = pin_q[0];
    assign rcv_en  = pin_q[1];
    assign term_en = pin_q[2];

    // R3: disabled transceiver gives both pins off on the next edge.
    p_gate_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[XCVR_EN_BIT] |=> (!drv_en && !rcv_en));

    // R4: full duplex keeps both directions on.
    p_full_duplex_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[XCVR_EN_BIT] && ctrl_q[1:0] == 2'd0) |=> (drv_en && rcv_en));

    // R5: echo mode keeps the receiver on and keys the driver from DTR.
    p_echo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[XCVR_EN_BIT] && ctrl_q[1:0] == 2'd1) |=> (rcv_en && drv_en == $past(dtr)));

    // R6: half-duplex modes never drive and listen at once.
    p_half_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[XCVR_EN_BIT] && ctrl_q[1]) |=> (drv_en != rcv_en));

    // R7: pending or shifting data in automatic mode turns the driver on.
    p_auto_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[XCVR_EN_BIT] && ctrl_q[1:0] == 2'd3 && (tx_fifo_nonempty || tx_shift_busy))
        |=> drv_en);

    // R8: termination pin follows the stored bit one edge later.
    p_term_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (term_en == $past(ctrl_q[TERM_BIT])));

endmodule

// File: tb/xcvr_dir_ctrl_tb_top.sv
module xcvr_dir_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = 4'h0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       dtr = 1'b0;
    logic       tx_fifo_nonempty = 1'b0;
    logic       tx_shift_busy = 1'b0;
    logic       drv_en;
    logic       rcv_en;
    logic       term_en;

    int unsigned checks = 0;
    int unsigned errors = 0;
    int unsigned cycles = 0;
    logic [7:0]  model = 8'h03;
    int unsigned seed_dummy;

    always #5 clk = ~clk;

    xcvr_dir_ctrl dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .reg_addr         (reg_addr),
        .reg_wr           (reg_wr),
        .reg_wdata        (reg_wdata),
        .reg_rdata        (reg_rdata),
        .dtr              (dtr),
        .tx_fifo_nonempty (tx_fifo_nonempty),
        .tx_shift_busy    (tx_shift_busy),
        .drv_en           (drv_en),
        .rcv_en           (rcv_en),
        .term_en          (term_en)
    );

    // Expected {drv, rcv} from a control word and the inputs.
    function automatic logic [1:0] exp_dir(logic [7:0] c, logic d, logic f, logic b);
        logic tx;
        logic rx;
        case (c[1:0])
            2'd0: begin tx = 1'b1; rx = 1'b1; end
            2'd1: begin tx = d;    rx = 1'b1; end
            2'd2: begin tx = d;    rx = !d;   end
            default: begin tx = f | b; rx = !(f | b); end
        endcase
        if (!c[3]) begin
            tx = 1'b0;
            rx = 1'b0;
        end
        return {tx, rx};
    endfunction

    function automatic string tag_of(logic [7:0] c);
        if (!c[3]) return "R3";
        case (c[1:0])
            2'd0: return "R4";
            2'd1: return "R5";
            2'd2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, expect pins at next negedge.
    task automatic step(logic [3:0] a, logic w, logic [7:0] wd, logic d, logic f, logic b);
        logic [1:0] e;
        logic       et;
        string      tg;
        reg_addr = a; reg_wr = w; reg_wdata = wd;
        dtr = d; tx_fifo_nonempty = f; tx_shift_busy = b;
        e  = exp_dir(model, d, f, b);
        et = model[6];
        tg = tag_of(model);
        @(posedge clk);
        if (w && a == 4'hF) model = wd;
        @(negedge clk);
        check(tg, "drv_en", {7'd0, drv_en}, {7'd0, e[1]});
        check(tg, "rcv_en", {7'd0, rcv_en}, {7'd0, e[0]});
        check("R8", "term_en", {7'd0, term_en}, {7'd0, et});
        check("R2", "rdata", reg_rdata, (a == 4'hF) ? model : 8'h00);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL R9 watchdog: actual=timeout expected=completion");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin : main
        seed_dummy = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        reg_addr = 4'hF;
        #1;
        // R1: reset contents and pins
        check("R1", "reset rdata", reg_rdata, 8'h03);
        check("R1", "reset pins", {5'd0, term_en, rcv_en, drv_en}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: default is disabled even with traffic pending
        step(4'hF, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1);
        // R2: foreign write ignored, foreign read zero, all bits stored
        step(4'h3, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0);
        step(4'hF, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        step(4'hF, 1'b1, 8'hB5, 1'b0, 1'b0, 1'b0);
        step(4'hF, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        // R4: full duplex, enabled, termination on
        step(4'hF, 1'b1, 8'h48, 1'b0, 1'b0, 1'b0);
        step(4'hF, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        // R5: echo mode with DTR toggling
        step(4'hF, 1'b1, 8'h09, 1'b0, 1'b0, 1'b0);
        step(4'hF, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        // R9: a DTR change is not visible before the next edge
        dtr = 1'b1;
        #1;
        check("R9", "drv_en before edge", {7'd0, drv_en}, 8'h00);
        step(4'hF, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
        step(4'hF, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        // R6: DTR-keyed half duplex
        step(4'hF, 1'b1, 8'h0A, 1'b1, 1'b0, 1'b0);
        step(4'hF, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
        step(4'hF, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        // R7: automatic mode, FIFO drains then last stop bit leaves
        step(4'hF, 1'b1, 8'h0B, 1'b0, 1'b0, 1'b0);
        step(4'hF, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
        step(4'hF, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        step(4'hF, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        step(4'hF, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
        step(4'hF, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        // R3: disable while sending in automatic mode, termination kept
        step(4'hF, 1'b1, 8'h43, 1'b0, 1'b1, 1'b1);
        step(4'hF, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1);

        // Random mix: writes landing on the same cycle as input changes
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            logic [3:0]  a;
            r = $urandom;
            a = (r[3:2] != 2'b00) ? 4'hF : r[7:4];
            step(a, r[8] & r[9], r[23:16], r[10], r[11], r[12]);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule